// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block decides, cycle by cycle, whether the high-side source of a motor bridge may conduct. When a digital current-sense trip arrives while the source is on and armed, the source is switched off for a fixed number of clock cycles. During this off phase the winding current recirculates. When the off phase ends, the source turns back on behind a blanking window in which further trips are ignored, so the turn-on current spike cannot cause a false trip.

An external PWM input (active high means chop) also controls the source. This input first passes through a deglitch filter. While the filtered input is high, the source is off and the current decays slowly through synchronous rectification. If the filtered input stays high long enough, the block enters standby and turns every output off. A change of direction, or a return of the PWM input to the on level, restarts blanking. An overvoltage flag suppresses synchronous rectification at once. The analog comparator, the reference and the gate drivers are outside this block.

Top module: `offtime_chopper`

## Requirements
- R1: When `trip_i` is high on a clock edge while the source is on and not blanked, `src_on_o` goes low after that edge and stays low for exactly `OFF_CYC` cycles.
- R2: After the off-time, `src_on_o` returns high and a blanking window of `BLANK_CYC` cycles starts. Trips sampled inside the window are ignored. A trip held high is honoured on the first edge after the window.
- R3: A change of `dir_i` while the source is on restarts the blanking window. If a trip arrives in the same cycle as the direction change, the trip is ignored and the source stays on.
- R4: While the filtered PWM level is high, `src_on_o` is 0 and `sync_rect_o` is 1, provided no overvoltage is present and the block is not in standby.
- R5: The filtered PWM level takes a new value of `pwm_n_i` only after that value has been sampled on `GLITCH_CYC` consecutive edges. A shorter pulse has no effect on `src_on_o`.
- R6: When the filtered PWM level has been high for `STBY_CYC` cycles, `standby_o` rises and both `src_on_o` and `sync_rect_o` are 0.
- R7: `ovp_i` high forces `sync_rect_o` low in the same cycle, in every phase.
- R8: Standby ends when the filtered PWM level returns low. The source then restarts inside a blanking window, so a trip at that point is ignored.
- R9: During and right after reset, `src_on_o` and `standby_o` are 0, and the filtered PWM level starts high (chop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Current-sense comparator trip, high when the limit is reached |
| pwm_n_i | input | 1 | External PWM input: 0 drives, 1 chops |
| dir_i | input | 1 | Rotation direction; any change restarts blanking |
| ovp_i | input | 1 | Supply overvoltage flag; suppresses synchronous rectification |
| src_on_o | output | 1 | Source enable: 1 lets the high-side switch conduct |
| sync_rect_o | output | 1 | Synchronous rectification enable during current decay |
| standby_o | output | 1 | Standby indication; all drive is off while high |

## Verification
Two collisions matter most. The first is a comparator trip that arrives in the same cycle as a direction change. The bench drives both on one edge, and the source must stay on because the restarted blanking window takes priority. The second is the end of standby, where the restart blanking and a trip coincide. The bench raises a trip on the first cycle the source is back on, and expects the trip to be ignored. A behavioural model steps through the same cycles and compares all three outputs on every clock.

// File: rtl/chop_pkg.sv
// Shared types of the off-time chopper.
// Assumes nothing beyond a single clock domain.
package chop_pkg;
    typedef enum logic [1:0] {
        PH_DRIVE = 2'd0,  // source on, trips armed
        PH_BLANK = 2'd1,  // source on, trips ignored
        PH_OFF   = 2'd2,  // fixed off-time running
        PH_CHOP  = 2'd3   // external PWM holds source off
    } phase_t;
endpackage

// File: rtl/chop_enb_filter.sv
// Deglitches the external PWM input.
// The output takes a new input level only after GLITCH_CYC consecutive samples
// of that level. The input is assumed to be already synchronous to clk.
// Out of reset the output is high (chop).
module chop_enb_filter #(
    parameter int GLITCH_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int GW = $clog2(GLITCH_CYC + 1);

    logic [GW-1:0] run_q;

    // Count the run of samples that differ from the held level; adopt the new level once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o <= 1'b1;
            run_q  <= '0;
        end else if (raw_i == filt_o) begin
            run_q <= '0;
        end else if (run_q == GW'(GLITCH_CYC - 1)) begin
            filt_o <= raw_i;
            run_q  <= '0;
        end else begin
            run_q <= run_q + GW'(1);
        end
    end

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> ($past(raw_i) == filt_o)); // R5
endmodule

// File: rtl/chop_standby_det.sv
// Detects a filtered PWM level held high for STBY_CYC cycles.
// The standby flag rises after that many high cycles and clears on the first
// edge that sees the level low. The count saturates at the limit.
module chop_standby_det #(
    parameter int STBY_CYC = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enb_f_i,
    output logic stby_o
);
    localparam int SW = $clog2(STBY_CYC + 1);

    logic [SW-1:0] hi_q;

    // Measure how long the filtered level has been high, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (!enb_f_i) begin
            hi_q <= '0;
        end else if (hi_q != SW'(STBY_CYC)) begin
            hi_q <= hi_q + SW'(1);
        end
    end

    assign stby_o = (hi_q == SW'(STBY_CYC));

    AST_STBY_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stby_o) |-> $past(enb_f_i)); // R6
endmodule

// File: rtl/chop_phase_ctrl.sv
// Sequences drive, blanking, fixed off-time and chop phases.
// Assumes trip_i and dir_i are synchronous to clk. enb_f_i comes from the
// deglitch filter, and stby_i from the standby detector.
module chop_phase_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 500,
    parameter int BLANK_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic dir_i,
    input  logic enb_f_i,
    input  logic stby_i,
    input  logic ovp_i,
    output logic src_on_o,
    output logic sync_rect_o
);
    localparam int TMAX = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;
    logic          dir_q;
    logic          dir_chg;
    logic          off_done;
    logic          blank_done;

    assign dir_chg    = (dir_i != dir_q);
    assign off_done   = (cnt_q == CW'(OFF_CYC - 1));
    assign blank_done = (cnt_q == CW'(BLANK_CYC - 1));

    // Remember the last direction so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b0;
        else        dir_q <= dir_i;
    end

    // Phase sequencing: chop takes priority, then direction restart, then trip, then timer expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_CHOP;
            cnt_q <= '0;
        end else if (enb_f_i) begin
            ph_q  <= PH_CHOP;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_CHOP: begin
                    ph_q  <= PH_BLANK;
                    cnt_q <= '0;
                end
                PH_BLANK: begin
                    if (dir_chg) begin
                        cnt_q <= '0;
                    end else if (blank_done) begin
                        ph_q  <= PH_DRIVE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_DRIVE: begin
                    if (dir_chg) begin
                        ph_q  <= PH_BLANK;
                        cnt_q <= '0;
                    end else if (trip_i) begin
                        ph_q  <= PH_OFF;
                        cnt_q <= '0;
                    end
                end
                default: begin
                    if (off_done) begin
                        ph_q  <= PH_BLANK;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    // Output decode: source on in drive or blank; synchronous rectification while current decays.
    always_comb begin
        src_on_o    = (ph_q == PH_DRIVE) || (ph_q == PH_BLANK);
        sync_rect_o = ((ph_q == PH_OFF) || (ph_q == PH_CHOP)) && !stby_i && !ovp_i;
    end

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_OFF && !enb_f_i && !off_done) |=> (ph_q == PH_OFF)); // R1
    AST_OFF_ENDS_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_OFF && !enb_f_i && off_done) |=> (ph_q == PH_BLANK)); // R2
    AST_BLANK_IGNORES_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BLANK && !enb_f_i) |=> (ph_q != PH_OFF)); // R2
    AST_DIR_BEATS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DRIVE && dir_chg && !enb_f_i) |=> src_on_o); // R3
    AST_CHOP_SOURCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        enb_f_i |=> !src_on_o); // R4
endmodule

// File: rtl/offtime_chopper.sv
// Fixed off-time current chopper, top level.
// Connects the PWM deglitch filter, the standby detector and the phase
// sequencer. All inputs are assumed to be synchronous to clk.
module offtime_chopper #(
    parameter int OFF_CYC    = 500,
    parameter int BLANK_CYC  = 30,
    parameter int GLITCH_CYC = 10,
    parameter int STBY_CYC   = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic pwm_n_i,
    input  logic dir_i,
    input  logic ovp_i,
    output logic src_on_o,
    output logic sync_rect_o,
    output logic standby_o
);
    logic enb_f;
    logic stby;

    chop_enb_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pwm_n_i),
        .filt_o (enb_f)
    );

    chop_standby_det #(.STBY_CYC(STBY_CYC)) u_stby (
        .clk     (clk),
        .rst_n   (rst_n),
        .enb_f_i (enb_f),
        .stby_o  (stby)
    );

    chop_phase_ctrl #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_i      (trip_i),
        .dir_i       (dir_i),
        .enb_f_i     (enb_f),
        .stby_i      (stby),
        .ovp_i       (ovp_i),
        .src_on_o    (src_on_o),
        .sync_rect_o (sync_rect_o)
    );

    assign standby_o = stby;

    AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (!src_on_o && !sync_rect_o)); // R6
    AST_OVP_NO_RECT: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_i |-> !sync_rect_o); // R7
endmodule

// File: tb/sim_offtime_chopper.sv
module sim_offtime_chopper;
    localparam int CLK_P = 10;
    localparam int G = 4;
    localparam int O = 20;
    localparam int B = 6;
    localparam int S = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip = 1'b0, pwm_n = 1'b0, dir = 1'b0, ovp = 1'b0;
    logic src_on, sync_rect, standby;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    offtime_chopper #(.OFF_CYC(O), .BLANK_CYC(B), .GLITCH_CYC(G), .STBY_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .pwm_n_i(pwm_n), .dir_i(dir),
        .ovp_i(ovp), .src_on_o(src_on), .sync_rect_o(sync_rect), .standby_o(standby)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference: mode 0 drive, 1 blank, 2 off, 3 chop
    bit m_filt = 1'b1;
    int m_run = 0, m_high = 0, m_mode = 3, m_left = 0;
    bit m_dir = 1'b0;

    always @(posedge clk) begin
        bit was_filt;
        bit turned;
        cyc++;
        if (!rst_n) begin
            m_filt = 1'b1; m_run = 0; m_high = 0; m_mode = 3; m_left = 0; m_dir = 1'b0;
        end else begin
            was_filt = m_filt;
            turned = (dir !== m_dir);
            if (!was_filt) m_high = 0;
            else if (m_high < S) m_high++;
            if (was_filt) m_mode = 3;
            else if (m_mode == 3) begin m_mode = 1; m_left = B; end
            else if (m_mode == 1) begin
                if (turned) m_left = B;
                else begin m_left--; if (m_left == 0) m_mode = 0; end
            end else if (m_mode == 0) begin
                if (turned) begin m_mode = 1; m_left = B; end
                else if (trip) begin m_mode = 2; m_left = O; end
            end else begin
                m_left--;
                if (m_left == 0) begin m_mode = 1; m_left = B; end
            end
            if (pwm_n !== m_filt) begin
                m_run++;
                if (m_run == G) begin m_filt = pwm_n; m_run = 0; end
            end else m_run = 0;
            m_dir = dir;
        end
        #(CLK_P/4);
        begin
            bit e_src, e_stby, e_sr;
            e_src  = (m_mode == 0) || (m_mode == 1);
            e_stby = (m_high == S);
            e_sr   = ((m_mode == 2) || (m_mode == 3)) && !e_stby && !ovp;
            check(src_on === e_src,     "R1 src_on_o model", int'(src_on), int'(e_src));
            check(standby === e_stby,   "R6 standby_o model", int'(standby), int'(e_stby));
            check(sync_rect === e_sr,   "R7 sync_rect_o model", int'(sync_rect), int'(e_sr));
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        check(src_on === 1'b0, "R9 source off in reset", int'(src_on), 0);
        check(standby === 1'b0, "R9 no standby in reset", int'(standby), 0);
        rst_n = 1'b1;
        wait_n(20);
        check(src_on === 1'b1, "R9 drive after filter settles low", int'(src_on), 1);

        // R1: single-cycle trip gives exactly O cycles off
        trip = 1'b1; wait_n(1); trip = 1'b0;
        check(src_on === 1'b0, "R1 off after trip", int'(src_on), 0);
        check(sync_rect === 1'b1, "R4 rectify during off-time", int'(sync_rect), 1);
        wait_n(O - 1);
        check(src_on === 1'b0, "R1 still off at end of off-time", int'(src_on), 0);
        wait_n(1);
        check(src_on === 1'b1, "R2 on after off-time", int'(src_on), 1);

        // R2: trip held through the blanking window
        trip = 1'b1;
        wait_n(B);
        check(src_on === 1'b1, "R2 trip ignored while blanked", int'(src_on), 1);
        wait_n(1);
        check(src_on === 1'b0, "R2 trip honoured after blanking", int'(src_on), 0);
        trip = 1'b0;
        ovp = 1'b1; wait_n(1);
        check(sync_rect === 1'b0, "R7 overvoltage blocks rectify", int'(sync_rect), 0);
        ovp = 1'b0;
        wait_n(O + B + 4);

        // R3: direction change and trip on the same edge
        dir = 1'b1; trip = 1'b1; wait_n(1); trip = 1'b0;
        check(src_on === 1'b1, "R3 direction restart beats trip", int'(src_on), 1);
        wait_n(B + 3);

        // R5: short PWM pulse rejected
        pwm_n = 1'b1; wait_n(G - 1); pwm_n = 1'b0;
        wait_n(3);
        check(src_on === 1'b1, "R5 short pulse rejected", int'(src_on), 1);

        // R4: PWM high chops
        pwm_n = 1'b1; wait_n(G + 2);
        check(src_on === 1'b0, "R4 chop turns source off", int'(src_on), 0);
        check(sync_rect === 1'b1, "R4 slow decay rectifies", int'(sync_rect), 1);

        // R6: long high enters standby
        wait_n(S + 5);
        check(standby === 1'b1, "R6 standby after long high", int'(standby), 1);
        check(sync_rect === 1'b0, "R6 rectify off in standby", int'(sync_rect), 0);

        // R8: exit standby into blanking; trip there ignored
        pwm_n = 1'b0; wait_n(G + 2);
        check(standby === 1'b0, "R8 standby cleared", int'(standby), 0);
        check(src_on === 1'b1, "R8 source restarts", int'(src_on), 1);
        trip = 1'b1; wait_n(1); trip = 1'b0;
        check(src_on === 1'b1, "R8 trip ignored in restart blanking", int'(src_on), 1);
        wait_n(B + 4);
        finish_run();
    end
endmodule